// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block serves several requesters that share one small word-addressed memory and gives them an atomic read-modify-write building block. A requester issues a load-linked to read a word; the block returns the word and remembers, for that requester alone, a reservation on the address. When the requester later issues a store-conditional to that address, the block writes the new value only if nobody else has written the address since the load-linked. It then returns a condition flag: 1 on success, 0 on failure. On failure, software goes back to the load-linked and tries again.

All writes go through one shared write port. The port carries at most one write per cycle and is granted by fixed priority. Every requester's reservation watches this port. A store-conditional that has already lost its reservation finishes at once without asking for the port. A failing store-conditional therefore never puts a write on the port and never changes memory.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 2'b01) accepted at a clock edge returns the word's current value on `rsp_rdata_o` with `rsp_valid_o` high in the following cycle, and sets a reservation for that requester on the address.
- R2: A store-conditional (op code 2'b11) from a requester holding a reservation on the same address, with no write to that address by another requester in between, drives one write on the shared port (`wr_valid_o`, `wr_src_o`, `wr_addr_o`, `wr_data_o`), updates memory, and reports `rsp_ok_o` = 1.
- R3: A store-conditional after another requester has written the reserved address reports `rsp_ok_o` = 0, leaves memory unchanged and produces no write on the shared port.
- R4: A store-conditional without a matching reservation is accepted in its request cycle (`req_ready_o` high) with `wr_valid_o` low, and does not wait for the port.
- R5: When two store-conditionals to the same reserved address arrive together, the lower index wins the port and succeeds. Its write breaks the other requester's reservation, so the other requester completes with `rsp_ok_o` = 0 one cycle later and does not write.
- R6: Each requester holds one reservation at most. A new load-linked replaces the old one, and a store-conditional to the earlier address then fails.
- R7: A successful store-conditional, or a plain store (op code 2'b10) from the same requester, clears that requester's own reservation, so a following store-conditional fails.
- R8: After reset there are no valid reservations and no pending responses, and every memory word reads as zero. A store-conditional with no load-linked before it fails.
- R9: Stores and store-conditionals that want to write are granted one per cycle, lowest requester index first. A requester that is not granted sees `req_ready_o` low and keeps its request until it is granted.
- R10: A plain load (op code 2'b00) returns the word and does not touch reservations. A write to a different address does not break a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_REQ | Request valid, one bit per requester |
| req_op_i | input | 2*NUM_REQ | Op per requester: 00 load, 01 load-linked, 10 store, 11 store-conditional |
| req_addr_i | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata_i | input | DATA_W*NUM_REQ | Store data per requester |
| req_ready_o | output | NUM_REQ | Request accepted at this edge when valid |
| rsp_valid_o | output | NUM_REQ | Response valid, one cycle after accept |
| rsp_ok_o | output | NUM_REQ | Condition flag; 0 only for a failed store-conditional |
| rsp_rdata_o | output | DATA_W*NUM_REQ | Read data for loads and load-linked |
| wr_valid_o | output | 1 | Shared write port active this cycle |
| wr_src_o | output | clog2(NUM_REQ) | Index of the granted writer |
| wr_addr_o | output | ADDR_W | Address written |
| wr_data_o | output | DATA_W | Data written |

## Verification
Some properties are checked on every cycle: at most one grant, grants only to requesters that asked, the lowest requester always winning, memory holding still while the port is idle, a reservation dying after another requester writes its address, and a failed store-conditional never following its own write. Other behaviour shows only in the bench scenarios, because it depends on a history of requests: a successful store-conditional after an undisturbed load-linked, the two-way race on one word, replacement of a reservation by a newer load-linked, self-clearing by the requester's own store, and the reset state.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_LL    = 2'b01,
    OP_STORE = 2'b10,
    OP_SC    = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_subset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_low_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_own_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              snoop_own_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    if (set_i) begin
      valid_d = 1'b1;
      addr_d  = set_addr_i;
    end
    if (clr_own_i) valid_d = 1'b0;
    // a foreign write in the same cycle beats a fresh reservation
    if (snoop_valid_i && !snoop_own_i && snoop_addr_i == addr_d) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  p_snoop_break_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && snoop_valid_i && !snoop_own_i && snoop_addr_i == addr_q && !set_i)
    |=> !valid_q);
  p_ll_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_own_i && !(snoop_valid_i && snoop_addr_i == set_addr_i))
    |=> (valid_q && addr_q == $past(set_addr_i)));
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_RD   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [N_RD*ADDR_W-1:0]   raddr_i,
  output logic [N_RD*DATA_W-1:0]   rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [Depth-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g*DATA_W +: DATA_W] = mem_q[raddr_i[g*ADDR_W +: ADDR_W]];
  end

  p_mem_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int SrcW   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [2*NUM_REQ-1:0]        req_op_i,
  input  logic [ADDR_W*NUM_REQ-1:0]   req_addr_i,
  input  logic [DATA_W*NUM_REQ-1:0]   req_wdata_i,
  output logic [NUM_REQ-1:0]          req_ready_o,
  output logic [NUM_REQ-1:0]          rsp_valid_o,
  output logic [NUM_REQ-1:0]          rsp_ok_o,
  output logic [DATA_W*NUM_REQ-1:0]   rsp_rdata_o,
  output logic                        wr_valid_o,
  output logic [SrcW-1:0]             wr_src_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [DATA_W-1:0]           wr_data_o
);
  logic [NUM_REQ-1:0]        hit, wants_wr, gnt, accept, resv_valid;
  logic [ADDR_W-1:0]         resv_addr [NUM_REQ];
  logic [DATA_W*NUM_REQ-1:0] rd_word;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic              rsp_valid_q, rsp_ok_q;
    logic [DATA_W-1:0] rdata_q;

    assign op   = op_e'(req_op_i[2*g +: 2]);
    assign addr = req_addr_i[g*ADDR_W +: ADDR_W];
    assign hit[g] = resv_valid[g] && (resv_addr[g] == addr);
    // a store-conditional without reservation fails early and never arbitrates
    assign wants_wr[g] = req_valid_i[g] &&
                         ((op == OP_STORE) || (op == OP_SC && hit[g]));
    assign req_ready_o[g] = !wants_wr[g] || gnt[g];
    assign accept[g] = req_valid_i[g] && req_ready_o[g];

    llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .set_i        (accept[g] && op == OP_LL),
      .set_addr_i   (addr),
      .clr_own_i    (gnt[g]),
      .snoop_valid_i(wr_valid_o),
      .snoop_addr_i (wr_addr_o),
      .snoop_own_i  (gnt[g]),
      .valid_o      (resv_valid[g]),
      .addr_o       (resv_addr[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_valid_q <= 1'b0;
        rsp_ok_q    <= 1'b0;
        rdata_q     <= '0;
      end else begin
        rsp_valid_q <= accept[g];
        if (accept[g]) begin
          rsp_ok_q <= !(op == OP_SC && !hit[g]);
          rdata_q  <= (op == OP_LOAD || op == OP_LL) ?
                      rd_word[g*DATA_W +: DATA_W] : '0;
        end
      end
    end

    assign rsp_valid_o[g]                   = rsp_valid_q;
    assign rsp_ok_o[g]                      = rsp_ok_q;
    assign rsp_rdata_o[g*DATA_W +: DATA_W]  = rdata_q;

    p_fail_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o[g] && !rsp_ok_o[g]) |-> !$past(wr_valid_o && wr_src_o == SrcW'(g)));
    p_wait_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[g] && !req_ready_o[g]) |=> !rsp_valid_o[g]);
  end

  llsc_prio_arb #(.N(NUM_REQ)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (wants_wr),
    .gnt_o (gnt)
  );

  always_comb begin
    wr_valid_o = |gnt;
    wr_src_o   = '0;
    wr_addr_o  = '0;
    wr_data_o  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (gnt[i]) begin
        wr_src_o  = SrcW'(i);
        wr_addr_o = req_addr_i[i*ADDR_W +: ADDR_W];
        wr_data_o = req_wdata_i[i*DATA_W +: DATA_W];
      end
    end
  end

  llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RD(NUM_REQ)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_valid_o),
    .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o),
    .raddr_i(req_addr_i),
    .rdata_o(rd_word)
  );
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [1:0] LD = 2'b00, LL = 2'b01, ST = 2'b10, SC = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    req_ready, rsp_valid, rsp_ok;
  logic [DW*N-1:0] rsp_rdata;
  logic            wr_valid;
  logic [1:0]      wr_src;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
    .rsp_ok_o(rsp_ok), .rsp_rdata_o(rsp_rdata), .wr_valid_o(wr_valid),
    .wr_src_o(wr_src), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(int i, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid[i] = 1'b1;
    req_op[2*i +: 2] = op;
    req_addr[i*AW +: AW] = a;
    req_wdata[i*DW +: DW] = d;
  endtask

  task automatic drop(int i);
    req_valid[i] = 1'b0;
  endtask

  // one request, one cycle; returns ready and port activity seen in the request cycle
  task automatic one(int i, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                     output logic rdy, output logic wv, output logic ok,
                     output logic [DW-1:0] rd);
    @(negedge clk);
    drive(i, op, a, d);
    #1;
    rdy = req_ready[i];
    wv  = wr_valid;
    @(negedge clk);
    ok = rsp_ok[i];
    rd = rsp_rdata[i*DW +: DW];
    drop(i);
  endtask

  task automatic t_reset;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    chk("R8 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R8 wr_valid after reset", 32'(wr_valid), 0);
    one(0, SC, 4'd3, 32'hDEAD, rdy, wv, ok, rd);
    chk("R8 sc without ll fails", 32'(ok), 0);
    chk("R4 early fail ready", 32'(rdy), 1);
    chk("R4 early fail no write", 32'(wv), 0);
    one(0, LD, 4'd3, 0, rdy, wv, ok, rd);
    chk("R8 memory zero", rd, 0);
  endtask

  task automatic t_basic;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(1, ST, 4'd5, 32'hA5, rdy, wv, ok, rd);
    chk("R9 lone store written", 32'(wv), 1);
    one(1, LL, 4'd5, 0, rdy, wv, ok, rd);
    chk("R1 ll data", rd, 32'hA5);
    one(1, SC, 4'd5, 32'h55, rdy, wv, ok, rd);
    chk("R2 sc ok", 32'(ok), 1);
    chk("R2 sc writes port", 32'(wv), 1);
    one(1, LD, 4'd5, 0, rdy, wv, ok, rd);
    chk("R2 memory updated", rd, 32'h55);
    one(1, SC, 4'd5, 32'h66, rdy, wv, ok, rd);
    chk("R7 second sc fails", 32'(ok), 0);
    one(1, LD, 4'd5, 0, rdy, wv, ok, rd);
    chk("R7 memory kept", rd, 32'h55);
  endtask

  task automatic t_break;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(2, LL, 4'd7, 0, rdy, wv, ok, rd);
    one(3, ST, 4'd7, 32'h77, rdy, wv, ok, rd);
    one(2, SC, 4'd7, 32'h99, rdy, wv, ok, rd);
    chk("R3 broken sc fails", 32'(ok), 0);
    chk("R3 no write on port", 32'(wv), 0);
    chk("R4 broken sc ready at once", 32'(rdy), 1);
    one(2, LD, 4'd7, 0, rdy, wv, ok, rd);
    chk("R3 memory unchanged", rd, 32'h77);
  endtask

  task automatic t_other_addr;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(2, LL, 4'd8, 0, rdy, wv, ok, rd);
    one(3, ST, 4'd9, 32'h9, rdy, wv, ok, rd);
    one(2, LD, 4'd8, 0, rdy, wv, ok, rd);
    one(2, SC, 4'd8, 32'h88, rdy, wv, ok, rd);
    chk("R10 other address keeps reservation", 32'(ok), 1);
  endtask

  task automatic t_replace;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(0, LL, 4'd10, 0, rdy, wv, ok, rd);
    one(0, LL, 4'd11, 0, rdy, wv, ok, rd);
    one(0, SC, 4'd10, 32'h1A, rdy, wv, ok, rd);
    chk("R6 old reservation gone", 32'(ok), 0);
    one(0, SC, 4'd11, 32'h1B, rdy, wv, ok, rd);
    chk("R6 new reservation holds", 32'(ok), 1);
  endtask

  task automatic t_own_store;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(1, LL, 4'd12, 0, rdy, wv, ok, rd);
    one(1, ST, 4'd12, 32'hC0, rdy, wv, ok, rd);
    one(1, SC, 4'd12, 32'hC1, rdy, wv, ok, rd);
    chk("R7 own store clears reservation", 32'(ok), 0);
  endtask

  task automatic t_race;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    one(1, LL, 4'd4, 0, rdy, wv, ok, rd);
    one(2, LL, 4'd4, 0, rdy, wv, ok, rd);
    @(negedge clk);
    drive(1, SC, 4'd4, 32'h11);
    drive(2, SC, 4'd4, 32'h22);
    #1;
    chk("R5 lower index ready", 32'(req_ready[1]), 1);
    chk("R9 loser waits", 32'(req_ready[2]), 0);
    chk("R5 port source", 32'(wr_src), 1);
    @(negedge clk);
    drop(1);
    chk("R5 winner ok", 32'({rsp_valid[1], rsp_ok[1]}), 3);
    chk("R9 loser no response yet", 32'(rsp_valid[2]), 0);
    #1;
    chk("R5 loser now ready", 32'(req_ready[2]), 1);
    chk("R5 loser no write", 32'(wr_valid), 0);
    @(negedge clk);
    drop(2);
    chk("R5 loser fails", 32'({rsp_valid[2], rsp_ok[2]}), 2);
    one(0, LD, 4'd4, 0, rdy, wv, ok, rd);
    chk("R5 winner data kept", rd, 32'h11);
  endtask

  task automatic t_prio;
    logic rdy, wv, ok;
    logic [DW-1:0] rd;
    @(negedge clk);
    drive(3, ST, 4'd1, 32'h31);
    drive(0, ST, 4'd2, 32'h02);
    #1;
    chk("R9 index0 first", 32'({wr_valid, wr_src}), 32'h4);
    chk("R9 index3 stalled", 32'(req_ready[3]), 0);
    @(negedge clk);
    drop(0);
    #1;
    chk("R9 index3 next", 32'({wr_valid, wr_src}), 32'h7);
    @(negedge clk);
    drop(3);
    one(0, LD, 4'd1, 0, rdy, wv, ok, rd);
    chk("R9 held store data", rd, 32'h31);
    one(0, LD, 4'd2, 0, rdy, wv, ok, rd);
    chk("R9 first store data", rd, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_break();
    t_other_addr();
    t_replace();
    t_own_store();
    t_race();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule